// File: doc/BRIEF.md
# Sequential Next-Page Translation Prefetcher

This block pairs a small fully associative translation cache with a separate prefetch buffer. Each lookup names a virtual page number. Both stores are searched in the same cycle. A hit in either store returns the physical page on the following cycle. A hit in the prefetch buffer also moves the entry into the translation cache and starts a background fetch of the next virtual page. When both stores miss, the block sends a demand request to the page walker and holds the requester until the translation comes back. It then installs the translation, answers the requester, and issues a prefetch for the page that follows.

The walker sits outside the block. It accepts one request per cycle, each tagged as demand or prefetch. Its responses carry the same tag, so a returning prefetch fills only the buffer. At most one demand and one prefetch are in flight at any time. Before a prefetch is sent, its target page is checked against the translation cache, the buffer and the prefetch already in flight. If a lookup misses on the page that the pending prefetch is already fetching, the block waits for that prefetch to return and sends no duplicate request.

Top module: `seqpf_tlb`

## Requirements
- R1: A lookup accepted while `lk_ready` is high, whose page is held in the translation cache or in the prefetch buffer, yields `rsp_valid`=1, `rsp_hit`=1 and that page's physical number on the next cycle. A hit in the translation cache sends no walker request.
- R2: A lookup that misses in both stores gives, on the next cycle, one walker request with `wreq_pref`=0 for that page. `lk_ready` stays low until the answer is given.
- R3: The cycle after a demand response (`wrsp_pref`=0), the block gives `rsp_valid`=1 and `rsp_hit`=0 with the returned physical page, and `lk_ready` is high again. This does not wait for any prefetch.
- R4: When a miss completes, a walker request with `wreq_pref`=1 for page+1 (modulo 2^VPN_W) appears in the same cycle as the answer, unless R6 or R8 suppresses it.
- R5: On a prefetch-buffer hit, the entry leaves the buffer and enters the translation cache, and a prefetch for page+1 is requested on the next cycle. A later lookup of the same page is then a cache hit and starts no prefetch.
- R6: No prefetch is requested if its target is already in the translation cache, already in the buffer, or is the prefetch in flight.
- R7: When full, each store replaces its least recently used entry. In the cache, a lookup hit or a fill counts as a use. In the buffer, a fill counts as a use.
- R8: At most one demand and one prefetch are outstanding. A prefetch trigger that arrives while another prefetch is in flight is dropped.
- R9: A prefetch response (`wrsp_pref`=1) fills only the prefetch buffer and produces no `rsp_valid`.
- R10: A miss on the page of the prefetch in flight sends no walker request. When that prefetch returns, the block answers with `rsp_hit`=0, installs the entry in the cache, and prefetches the next page.
- R11: After reset, `lk_ready`=1, `rsp_valid`=0, `wreq_valid`=0, and both stores are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_ready | output | 1 | Block can accept a lookup this cycle |
| rsp_valid | output | 1 | Translation answer present |
| rsp_hit | output | 1 | 1: answered from a store; 0: answered after a walk |
| rsp_ppn | output | PPN_W | Physical page of the answer |
| wreq_valid | output | 1 | Walker request present |
| wreq_pref | output | 1 | Request tag: 0 demand, 1 prefetch |
| wreq_vpn | output | VPN_W | Page the walker must translate |
| wrsp_valid | input | 1 | Walker response present |
| wrsp_pref | input | 1 | Response tag: 0 demand, 1 prefetch |
| wrsp_ppn | input | PPN_W | Physical page returned by the walker |

## Verification
The bench builds the block with a four-entry translation cache, a two-entry prefetch buffer and 8-bit page numbers. With these sizes, a short sequence of lookups fills both stores and drives least-recently-used evictions in each. It also lets the page after 0xFF wrap to 0x00, which tests the modulo rule for prefetch targets. A walker model with a prefetch latency that can be raised keeps a prefetch in flight long enough to reach the merge-with-pending-prefetch case and the dropped-trigger case.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;
  // Tag carried on walker requests and responses.
  typedef enum logic {
    REQ_DEMAND = 1'b0,
    REQ_PREF   = 1'b1
  } req_tag_e;
endpackage

// File: rtl/seqpf_store.sv
// Fully associative translation store with age-based LRU replacement.
// Port a: lookup (optional touch or drop). Port b: presence probe only.
module seqpf_store #(
  parameter int DEPTH = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] a_vpn,
  output logic             a_hit,
  output logic [PPN_W-1:0] a_ppn,
  input  logic             a_touch,
  input  logic             a_drop,
  input  logic [VPN_W-1:0] b_vpn,
  output logic             b_hit,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] AGE_MAX = IW'(DEPTH - 1);

  logic [DEPTH-1:0] vld_q, vld_d, a_match, b_match;
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [IW-1:0]    age_q [DEPTH];
  logic [IW-1:0]    age_d [DEPTH];
  logic [IW-1:0]    a_idx, vic_idx, upd_idx, upd_age;
  logic             upd_en, free_found;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign a_match[g] = vld_q[g] && (tag_q[g] == a_vpn);
    assign b_match[g] = vld_q[g] && (tag_q[g] == b_vpn);
  end

  assign a_hit = |a_match;
  assign b_hit = |b_match;

  always_comb begin
    a_idx = '0;
    a_ppn = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (a_match[i]) begin
        a_idx = IW'(i);
        a_ppn = ppn_q[i];
      end
    end
  end

  // Victim: lowest free slot, else the oldest entry.
  always_comb begin
    vic_idx    = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !free_found) begin
        vic_idx    = IW'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (age_q[i] == AGE_MAX) vic_idx = IW'(i);
      end
    end
  end

  assign upd_en  = ins_en || (a_touch && a_hit);
  assign upd_idx = ins_en ? vic_idx : a_idx;
  assign upd_age = age_q[upd_idx];

  always_comb begin
    vld_d = vld_q;
    if (a_drop) vld_d = vld_d & ~a_match;
    if (ins_en) vld_d[vic_idx] = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (upd_en) begin
        if (IW'(i) == upd_idx)         age_d[i] = '0;
        else if (age_q[i] < upd_age)   age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= IW'(i);
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[vic_idx] <= ins_vpn;
      ppn_q[vic_idx] <= ins_ppn;
    end
  end
endmodule

// File: rtl/seqpf_gate.sv
// Decides whether a prefetch trigger becomes a walker request.
module seqpf_gate #(
  parameter int VPN_W = 20
) (
  input  logic             trig,
  input  logic [VPN_W-1:0] tgt,
  input  logic             in_tlb,
  input  logic             in_pbuf,
  input  logic             pf_busy,
  input  logic             pf_ret,
  input  logic [VPN_W-1:0] pf_vpn,
  output logic             issue
);
  logic slot_free, dup_pf;
  assign slot_free = !pf_busy || pf_ret;
  assign dup_pf    = pf_busy && (pf_vpn == tgt);
  assign issue     = trig && slot_free && !dup_pf && !in_tlb && !in_pbuf;
endmodule

// File: rtl/seqpf_tlb.sv
module seqpf_tlb #(
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 16,
  parameter int TLB_DEPTH = 8,
  parameter int PB_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             wreq_valid,
  output logic             wreq_pref,
  output logic [VPN_W-1:0] wreq_vpn,
  input  logic             wrsp_valid,
  input  logic             wrsp_pref,
  input  logic [PPN_W-1:0] wrsp_ppn
);
  import seqpf_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // Control state.
  logic             dem_busy_q, dem_busy_d, dem_wait_q, dem_wait_d;
  logic [VPN_W-1:0] dem_vpn_q, dem_vpn_d;
  logic             pf_busy_q, pf_busy_d;
  logic [VPN_W-1:0] pf_vpn_q, pf_vpn_d;
  logic             rsp_valid_d, rsp_hit_d, wreq_valid_d, wreq_pref_d;
  logic [PPN_W-1:0] rsp_ppn_d;
  logic [VPN_W-1:0] wreq_vpn_d;

  // Store interfaces.
  logic             t_hit, p_hit_raw, t_in, p_in;
  logic [PPN_W-1:0] t_ppn, p_ppn;
  logic             t_ins, p_ins;
  logic [VPN_W-1:0] t_ins_vpn;
  logic [PPN_W-1:0] t_ins_ppn;

  logic acc, p_hit, miss, pf_ret, d_ret, direct, wait_pf, via_pf, done;
  logic trig, issue, dreq;
  logic [VPN_W-1:0] done_vpn, tgt;

  assign lk_ready = !dem_busy_q;
  assign acc      = lk_valid && lk_ready;
  assign p_hit    = p_hit_raw && !t_hit;
  assign miss     = acc && !t_hit && !p_hit_raw;
  assign pf_ret   = wrsp_valid && (req_tag_e'(wrsp_pref) == REQ_PREF);
  assign d_ret    = wrsp_valid && (req_tag_e'(wrsp_pref) == REQ_DEMAND);
  assign direct   = miss && pf_busy_q && pf_ret && (pf_vpn_q == lk_vpn);
  assign wait_pf  = miss && pf_busy_q && !pf_ret && (pf_vpn_q == lk_vpn);
  assign via_pf   = pf_ret && dem_wait_q;
  assign done     = d_ret || via_pf || direct;
  assign done_vpn = direct ? lk_vpn : dem_vpn_q;
  assign dreq     = miss && !direct && !wait_pf;

  assign trig = (acc && p_hit) || done;
  assign tgt  = ((acc && p_hit) ? lk_vpn : done_vpn) + 1'b1;

  assign t_ins     = (acc && p_hit) || done;
  assign t_ins_vpn = (acc && p_hit) ? lk_vpn : done_vpn;
  assign t_ins_ppn = (acc && p_hit) ? p_ppn : wrsp_ppn;
  assign p_ins     = pf_ret && !dem_wait_q && !direct;

  seqpf_store #(.DEPTH(TLB_DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n_i),
    .a_vpn(lk_vpn), .a_hit(t_hit), .a_ppn(t_ppn),
    .a_touch(acc), .a_drop(1'b0),
    .b_vpn(tgt), .b_hit(t_in),
    .ins_en(t_ins), .ins_vpn(t_ins_vpn), .ins_ppn(t_ins_ppn)
  );

  seqpf_store #(.DEPTH(PB_DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n_i),
    .a_vpn(lk_vpn), .a_hit(p_hit_raw), .a_ppn(p_ppn),
    .a_touch(1'b0), .a_drop(acc && !t_hit),
    .b_vpn(tgt), .b_hit(p_in),
    .ins_en(p_ins), .ins_vpn(pf_vpn_q), .ins_ppn(wrsp_ppn)
  );

  seqpf_gate #(.VPN_W(VPN_W)) u_gate (
    .trig(trig), .tgt(tgt), .in_tlb(t_in), .in_pbuf(p_in),
    .pf_busy(pf_busy_q), .pf_ret(pf_ret), .pf_vpn(pf_vpn_q), .issue(issue)
  );

  // Next state.
  always_comb begin
    dem_busy_d = dem_busy_q;
    dem_wait_d = dem_wait_q;
    dem_vpn_d  = dem_vpn_q;
    if (miss && !direct) begin
      dem_busy_d = 1'b1;
      dem_wait_d = wait_pf;
      dem_vpn_d  = lk_vpn;
    end
    if (d_ret || via_pf) begin
      dem_busy_d = 1'b0;
      dem_wait_d = 1'b0;
    end

    pf_busy_d = pf_busy_q;
    pf_vpn_d  = pf_vpn_q;
    if (pf_ret) pf_busy_d = 1'b0;
    if (issue) begin
      pf_busy_d = 1'b1;
      pf_vpn_d  = tgt;
    end

    rsp_valid_d  = (acc && (t_hit || p_hit)) || done;
    rsp_hit_d    = !done;
    rsp_ppn_d    = done ? wrsp_ppn : (t_hit ? t_ppn : p_ppn);
    wreq_valid_d = dreq || issue;
    wreq_pref_d  = issue ? REQ_PREF : REQ_DEMAND;
    wreq_vpn_d   = issue ? tgt : lk_vpn;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dem_busy_q <= 1'b0;
      dem_wait_q <= 1'b0;
      dem_vpn_q  <= '0;
      pf_busy_q  <= 1'b0;
      pf_vpn_q   <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_ppn    <= '0;
      wreq_valid <= 1'b0;
      wreq_pref  <= 1'b0;
      wreq_vpn   <= '0;
    end else begin
      dem_busy_q <= dem_busy_d;
      dem_wait_q <= dem_wait_d;
      if (miss) dem_vpn_q <= dem_vpn_d;
      pf_busy_q  <= pf_busy_d;
      if (issue) pf_vpn_q <= pf_vpn_d;
      rsp_valid  <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_hit <= rsp_hit_d;
        rsp_ppn <= rsp_ppn_d;
      end
      wreq_valid <= wreq_valid_d;
      if (wreq_valid_d) begin
        wreq_pref <= wreq_pref_d;
        wreq_vpn  <= wreq_vpn_d;
      end
    end
  end
endmodule

// File: rtl/seqpf_chk.sv
module seqpf_chk #(
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             wreq_valid,
  input logic             wreq_pref,
  input logic [VPN_W-1:0] wreq_vpn,
  input logic             wrsp_valid,
  input logic             wrsp_pref
);
  logic [VPN_W-1:0] last_vpn_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     last_vpn_q <= '0;
    else if (lk_valid && lk_ready)  last_vpn_q <= lk_vpn;
  end

  AST_DEMAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq_valid && !wreq_pref) |-> !lk_ready); // R2

  AST_DEMAND_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsp_valid && !wrsp_pref && !lk_ready) |=> (rsp_valid && !rsp_hit)); // R3

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> lk_ready); // R3

  AST_PF_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq_valid && wreq_pref) |-> (wreq_vpn == last_vpn_q + 1'b1)); // R4

  AST_PF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsp_valid && wrsp_pref && lk_ready && !lk_valid) |=> !rsp_valid); // R9
endmodule

bind seqpf_tlb seqpf_chk #(.VPN_W(VPN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .wreq_valid(wreq_valid), .wreq_pref(wreq_pref), .wreq_vpn(wreq_vpn),
  .wrsp_valid(wrsp_valid), .wrsp_pref(wrsp_pref)
);

// File: tb/seqpf_tlb_tb_top.sv
module seqpf_tlb_tb_top;
  localparam int VW = 8;
  localparam int PW = 12;

  logic          clk, rst_n;
  logic          lk_valid, lk_ready, rsp_valid, rsp_hit;
  logic [VW-1:0] lk_vpn, wreq_vpn;
  logic [PW-1:0] rsp_ppn, wrsp_ppn;
  logic          wreq_valid, wreq_pref, wrsp_valid, wrsp_pref;

  seqpf_tlb #(.VPN_W(VW), .PPN_W(PW), .TLB_DEPTH(4), .PB_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_ppn(rsp_ppn), .wreq_valid(wreq_valid), .wreq_pref(wreq_pref),
    .wreq_vpn(wreq_vpn), .wrsp_valid(wrsp_valid), .wrsp_pref(wrsp_pref),
    .wrsp_ppn(wrsp_ppn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_look = 0, n_rsp = 0;
  int n_dreq = 0, n_preq = 0, plat = 4;
  logic [VW-1:0] last_pvpn;
  bit wk_on = 0;
  logic r_wv, r_wp;
  logic [VW-1:0] r_wvpn;

  function automatic logic [PW-1:0] pmap(input logic [VW-1:0] v);
    return {4'hA, v ^ 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Walker model: one demand and one prefetch slot.
  initial begin : walker
    bit d_pend, p_pend, p_before, d_before;
    int d_cnt, p_cnt;
    logic [VW-1:0] d_vpn, p_vpn;
    d_pend = 0; p_pend = 0; d_cnt = 0; p_cnt = 0; d_vpn = '0; p_vpn = '0;
    wrsp_valid = 1'b0; wrsp_pref = 1'b0; wrsp_ppn = '0;
    forever begin
      @(negedge clk);
      p_before = p_pend; d_before = d_pend;
      wrsp_valid = 1'b0; wrsp_pref = 1'b0;
      if (d_pend && d_cnt == 0) begin
        wrsp_valid = 1'b1; wrsp_pref = 1'b0; wrsp_ppn = pmap(d_vpn); d_pend = 0;
      end else if (p_pend && p_cnt == 0) begin
        wrsp_valid = 1'b1; wrsp_pref = 1'b1; wrsp_ppn = pmap(p_vpn); p_pend = 0;
      end
      if (d_pend && d_cnt > 0) d_cnt--;
      if (p_pend && p_cnt > 0) p_cnt--;
      if (wk_on && wreq_valid) begin
        if (wreq_pref) begin
          if (p_before) chk(0, "R8 second prefetch outstanding", 1, 0);
          p_pend = 1; p_vpn = wreq_vpn; p_cnt = plat - 1; n_preq++; last_pvpn = wreq_vpn;
        end else begin
          if (d_before) chk(0, "R8 second demand outstanding", 1, 0);
          d_pend = 1; d_vpn = wreq_vpn; d_cnt = 2; n_dreq++;
        end
      end
    end
  end

  initial begin : rsp_mon
    forever begin
      @(negedge clk);
      if (wk_on && rsp_valid) n_rsp++;
    end
  end

  // Lookup: eh = expected hit, dq = demand request expected.
  task automatic do_lookup(input logic [VW-1:0] v, input bit eh, input bit dq);
    int lat;
    bit got;
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; n_look++;
    @(negedge clk);
    lk_valid = 1'b0;
    lat = 1; got = 0;
    if (dq) begin
      chk(wreq_valid && !wreq_pref && wreq_vpn == v, "R2 demand request", int'(wreq_vpn), int'(v));
      chk(!lk_ready, "R2 ready low while walking", int'(lk_ready), 0);
    end else if (!eh) begin
      chk(!(wreq_valid && !wreq_pref), "R10 no duplicate demand", int'(wreq_valid), 0);
    end
    while (!got && lat < 200) begin
      if (rsp_valid) got = 1;
      else begin @(negedge clk); lat++; end
    end
    r_wv = wreq_valid; r_wp = wreq_pref; r_wvpn = wreq_vpn;
    chk(got, "R1/R3 answer arrives", got, 1);
    if (eh) chk(lat == 1, "R1 hit latency", lat, 1);
    chk(rsp_hit == eh, eh ? "R1 hit flag" : "R3 miss flag", int'(rsp_hit), int'(eh));
    chk(rsp_ppn == pmap(v), eh ? "R1 ppn" : "R3 ppn", int'(rsp_ppn), int'(pmap(v)));
  endtask

  // {vpn, hit, demand delta, prefetch delta, prefetch target}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {8'h10, 1'b0, 2'd1, 2'd1, 8'h11},
    {8'h11, 1'b1, 2'd0, 2'd1, 8'h12},
    {8'h12, 1'b1, 2'd0, 2'd1, 8'h13},
    {8'h10, 1'b1, 2'd0, 2'd0, 8'h00},
    {8'h13, 1'b1, 2'd0, 2'd1, 8'h14},
    {8'h30, 1'b0, 2'd1, 2'd1, 8'h31},
    {8'h11, 1'b0, 2'd1, 2'd0, 8'h00},
    {8'h12, 1'b0, 2'd1, 2'd0, 8'h00},
    {8'h14, 1'b1, 2'd0, 2'd1, 8'h15},
    {8'h40, 1'b0, 2'd1, 2'd1, 8'h41},
    {8'h31, 1'b0, 2'd1, 2'd1, 8'h32},
    {8'h41, 1'b1, 2'd0, 2'd1, 8'h42},
    {8'hFF, 1'b0, 2'd1, 2'd1, 8'h00},
    {8'h00, 1'b1, 2'd0, 2'd1, 8'h01},
    {8'h00, 1'b1, 2'd0, 2'd0, 8'h00}
  };

  initial begin : main
    int d0, p0;
    lk_valid = 1'b0; lk_vpn = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(lk_ready == 1'b1 && rsp_valid == 1'b0, "R11 reset outputs", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wk_on = 1;
    chk(lk_ready == 1'b1, "R11 ready after reset", int'(lk_ready), 1);
    chk(rsp_valid == 1'b0 && wreq_valid == 1'b0, "R11 idle after reset", int'(wreq_valid), 0);

    // Table: R1 R2 R3 R4 R5 R6 R7 (steps 7, 8, 11 depend on LRU eviction).
    for (int i = 0; i < NV; i++) begin
      d0 = n_dreq; p0 = n_preq;
      do_lookup(VEC[i][20:13], VEC[i][12], !VEC[i][12]);
      repeat (12) @(negedge clk);
      chk(n_dreq - d0 == int'(VEC[i][11:10]), "R2/R7 demand count", n_dreq - d0, int'(VEC[i][11:10]));
      chk(n_preq - p0 == int'(VEC[i][9:8]), "R4/R5/R6 prefetch count", n_preq - p0, int'(VEC[i][9:8]));
      if (VEC[i][9:8] != 2'd0)
        chk(last_pvpn == VEC[i][7:0], "R4 prefetch target", int'(last_pvpn), int'(VEC[i][7:0]));
    end

    // R10 and R3: miss on a page whose prefetch is in flight.
    plat = 40;
    d0 = n_dreq; p0 = n_preq;
    do_lookup(8'h60, 1'b0, 1'b1);
    chk(r_wv && r_wp && r_wvpn == 8'h61, "R3 released while prefetch starts", int'(r_wvpn), 8'h61);
    do_lookup(8'h61, 1'b0, 1'b0);
    repeat (50) @(negedge clk);
    chk(n_dreq - d0 == 1, "R10 no duplicate walk", n_dreq - d0, 1);
    chk(n_preq - p0 == 2, "R10 prefetch after merge", n_preq - p0, 2);
    chk(last_pvpn == 8'h62, "R10 next page prefetched", int'(last_pvpn), 8'h62);

    // R8: trigger while a prefetch is in flight is dropped.
    d0 = n_dreq; p0 = n_preq;
    do_lookup(8'h70, 1'b0, 1'b1);
    do_lookup(8'h90, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    chk(n_dreq - d0 == 2, "R8 demand count", n_dreq - d0, 2);
    chk(n_preq - p0 == 1, "R8 dropped trigger", n_preq - p0, 1);
    plat = 4;
    do_lookup(8'h91, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    do_lookup(8'h71, 1'b1, 1'b0);
    repeat (12) @(negedge clk);

    // R9: prefetch returns never produced an answer.
    chk(n_rsp == n_look, "R9 answers equal lookups", n_rsp, n_look);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule